// File: doc/BRIEF.md
# Two-bank interleaved SEC-DED memory mapper

The block sits between a single memory request port and two memory banks that work in an interleaved fashion. Each bank stores a 72-bit word made of 64 data bits and 8 check bits. Consecutive quadword addresses alternate between the two banks, so a stream of sequential accesses spreads evenly across both. On a write, the block computes single-error-correcting, double-error-detecting check bits. On a read, it checks the returned word, repairs any one flipped bit, and reports a word with two flipped bits as unrecoverable.

The address space is built from one or two memory sets. Each set is either small (16MB) or large (64MB), which gives totals of 16, 32, 64, 80 or 128MB. The mapper places the larger set at address zero and the smaller set directly after it, so the space has no holes. An address beyond the fitted total gets an out-of-range response and never reaches a bank.

A request is accepted only when the block is idle, and every accepted request gets exactly one response pulse. The control state machine has four states:
- ST_IDLE accepts a request. It moves to ST_ISSUE for an address in range, or straight to ST_RESP for one out of range.
- ST_ISSUE holds the bank request until that bank is ready. It then moves to ST_RESP for a write or to ST_WAITRD for a read.
- ST_WAITRD waits for the bank's read-valid and then moves to ST_RESP.
- ST_RESP drives the response for one cycle and returns to ST_IDLE.

Top module: `ilv_ecc_mapper`

## Requirements
- R1: The bank is chosen by byte address bit 3 (0 selects bank 0, 1 selects bank 1). Only the chosen bank's request line is ever high, and no two request lines are high together.
- R2: A bank word carries the request data in bits [63:0] and check bits in [71:64]. A clean read of a written quadword returns the same 64 bits with response code 0 (ok).
- R3: A read word with exactly one flipped bit, at any of the 72 positions, returns the original data with code 1 (corrected). ce_pulse is high only in that response cycle.
- R4: A read word with two flipped bits returns code 2 (uncorrectable). ue_addr then takes the request's byte address and holds it until the next such event.
- R5: A set is 16MB when its size input is 0 and 64MB when it is 1. Set 0 is always fitted, and set 1 is fitted when cfg_set1_fitted is 1.
  - Set 1 is mapped first only when it is larger than set 0; otherwise set 0 is first. The second set starts right after the first.
  - bank_addr[22] gives the set index, and bank_addr[21:0] gives byte offset bits [25:4] within that set.
- R6: An address at or above the sum of the fitted set sizes gets code 3 (out of range), for writes and reads alike, and no bank request is made.
- R7: req_ready is high only in ST_IDLE, and each accepted request gives exactly one single-cycle rsp_valid. While the selected bank holds bank_ready low, the request and bank_addr stay stable, and each stalled cycle adds one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_set0_large | input | 1 | Set 0 is 64MB when 1, 16MB when 0 |
| cfg_set1_fitted | input | 1 | Set 1 is installed |
| cfg_set1_large | input | 1 | Set 1 is 64MB when 1, 16MB when 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, quadword aligned (bits [2:0] ignored) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 0 ok, 1 corrected, 2 uncorrectable, 3 out of range |
| rsp_rdata | output | 64 | Read data, corrected where possible |
| ce_pulse | output | 1 | Corrected-error pulse |
| ue_addr | output | ADDR_W | Byte address of the last uncorrectable read |
| bank_req | output | 2 | Per-bank access request |
| bank_we | output | 1 | Access is a write |
| bank_addr | output | LARGE_LOG2-3 | {set index, row within set} |
| bank_wdata | output | 72 | {check bits, data} |
| bank_ready | input | 2 | Per-bank accept |
| bank_rvalid | input | 2 | Per-bank read data valid |
| bank_rdata | input | 144 | Bank 1 word in [143:72], bank 0 word in [71:0] |

## Verification
Address patterns are walked over every supported configuration:
- Addresses at the first and last quadword of each set tell the ordering of unequal sets apart.
- The first address past the total separates in-range from out-of-range decode.
- Addresses with bit 3 set and clear tell the two banks apart.

Error-injection patterns on the returned word each separate a different case:
- A single flip in a data bit, in a Hamming check bit, or in the overall parity bit must each be corrected.
- Two flips, including two in the check byte, must be reported and never miscorrected.

Zero and four-cycle bank stalls show that latency follows bank_ready.

// File: rtl/ilv_ecc_pkg.sv
package ilv_ecc_pkg;

    localparam int DW    = 64;
    localparam int EW    = 8;
    localparam int CW    = DW + EW;
    localparam int HW    = EW - 1;
    localparam int NBANK = 2;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_FIXED = 2'd1,
        RSP_FATAL = 2'd2,
        RSP_RANGE = 2'd3
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAITRD,
        ST_RESP
    } mst_e;

    // Hamming parity over positions 1..CW-1: powers of two carry chk, the
    // rest carry data bits in ascending order. With chk = 0 this yields the
    // check bits; with the stored check bits it yields the syndrome.
    function automatic logic [HW-1:0] ham_sum(input logic [DW-1:0] d,
                                              input logic [HW-1:0] chk);
        logic [HW-1:0] s;
        logic          b;
        int            k;
        s = '0;
        k = 0;
        for (int pos = 1; pos < CW; pos++) begin
            b = 1'b0;
            if ((pos & (pos - 1)) == 0) begin
                for (int i = 0; i < HW; i++)
                    if (pos == (1 << i)) b = chk[i];
            end else begin
                b = d[k];
                k++;
            end
            for (int i = 0; i < HW; i++)
                if (pos[i]) s[i] = s[i] ^ b;
        end
        return s;
    endfunction

endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
    parameter int ADDR_W     = 27,
    parameter int SMALL_LOG2 = 24,
    parameter int LARGE_LOG2 = 26
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cfg_set0_large,
    input  logic                    cfg_set1_fitted,
    input  logic                    cfg_set1_large,
    output logic                    in_range,
    output logic                    set_sel,
    output logic                    bank_sel,
    output logic [LARGE_LOG2-5:0]   row
);

    localparam int SUM_W = ADDR_W + 1;
    localparam logic [SUM_W-1:0] SMALL_SZ = SUM_W'(1) << SMALL_LOG2;
    localparam logic [SUM_W-1:0] LARGE_SZ = SUM_W'(1) << LARGE_LOG2;

    logic [SUM_W-1:0] sz0, sz1, first_sz, total, addr_w, off, sel_sz;
    logic             first_is_1;

    always_comb begin
        sz0        = cfg_set0_large ? LARGE_SZ : SMALL_SZ;
        sz1        = cfg_set1_fitted ? (cfg_set1_large ? LARGE_SZ : SMALL_SZ) : '0;
        first_is_1 = cfg_set1_fitted && cfg_set1_large && !cfg_set0_large;
        first_sz   = first_is_1 ? sz1 : sz0;
        total      = sz0 + sz1;
        addr_w     = SUM_W'(addr);
        in_range   = addr_w < total;
        if (addr_w < first_sz) begin
            off     = addr_w;
            set_sel = first_is_1;
            sel_sz  = first_sz;
        end else begin
            off     = addr_w - first_sz;
            set_sel = !first_is_1;
            sel_sz  = total - first_sz;
        end
        AST_OFF_IN_SET: assert (!in_range || (off < sel_sz)); // R5
    end

    assign bank_sel = off[3];
    assign row      = off[LARGE_LOG2-1:4];

endmodule

// File: rtl/ilv_secded_enc.sv
module ilv_secded_enc
    import ilv_ecc_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [EW-1:0] ecc
);

    logic [HW-1:0] ham;

    always_comb begin
        ham = ham_sum(data, '0);
        ecc = {^{data, ham}, ham};
    end

endmodule

// File: rtl/ilv_secded_dec.sv
module ilv_secded_dec
    import ilv_ecc_pkg::*;
(
    input  logic [CW-1:0] word,
    output logic [DW-1:0] data,
    output logic          fixed,
    output logic          fatal
);

    logic [DW-1:0] raw;
    logic [EW-1:0] ecc;
    logic [HW-1:0] syn;
    logic          par;

    assign raw = word[DW-1:0];
    assign ecc = word[CW-1:DW];

    always_comb begin
        int k;
        syn   = ham_sum(raw, ecc[HW-1:0]);
        par   = ^{raw, ecc};
        data  = raw;
        fixed = 1'b0;
        fatal = 1'b0;
        k     = 0;
        if (par) begin
            if (int'(syn) >= CW) begin
                fatal = 1'b1;
            end else begin
                fixed = 1'b1;
                for (int pos = 1; pos < CW; pos++) begin
                    if ((pos & (pos - 1)) != 0) begin
                        if (syn == HW'(pos)) data[k] = ~raw[k];
                        k++;
                    end
                end
            end
        end else if (syn != '0) begin
            fatal = 1'b1;
        end
        AST_FIX_XOR_FATAL: assert (!(fixed && fatal)); // R4
    end

endmodule

// File: rtl/ilv_ecc_mapper.sv
module ilv_ecc_mapper
    import ilv_ecc_pkg::*;
#(
    parameter int ADDR_W     = 27,
    parameter int SMALL_LOG2 = 24,
    parameter int LARGE_LOG2 = 26
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_set0_large,
    input  logic                     cfg_set1_fitted,
    input  logic                     cfg_set1_large,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [63:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_code,
    output logic [63:0]              rsp_rdata,
    output logic                     ce_pulse,
    output logic [ADDR_W-1:0]        ue_addr,
    output logic [1:0]               bank_req,
    output logic                     bank_we,
    output logic [LARGE_LOG2-4:0]    bank_addr,
    output logic [71:0]              bank_wdata,
    input  logic [1:0]               bank_ready,
    input  logic [1:0]               bank_rvalid,
    input  logic [143:0]             bank_rdata
);

    localparam int ROW_W = LARGE_LOG2 - 4;

    mst_e             state, state_nx;
    logic [ADDR_W-1:0] r_addr;
    logic             r_write;
    logic [DW-1:0]    r_wdata;
    logic             r_set;
    logic             r_bank;
    logic [ROW_W-1:0] r_row;
    rsp_code_e        r_code;
    logic [DW-1:0]    r_rdata;
    logic [ADDR_W-1:0] r_ue_addr;

    logic             map_in, map_set, map_bank;
    logic [ROW_W-1:0] map_row;
    logic [EW-1:0]    wr_ecc;
    logic [CW-1:0]    rd_word;
    logic [DW-1:0]    dec_data;
    logic             dec_fixed, dec_fatal;
    logic             sel_ready, sel_rvalid;

    ilv_addr_map #(
        .ADDR_W     (ADDR_W),
        .SMALL_LOG2 (SMALL_LOG2),
        .LARGE_LOG2 (LARGE_LOG2)
    ) u_map (
        .addr            (req_addr),
        .cfg_set0_large  (cfg_set0_large),
        .cfg_set1_fitted (cfg_set1_fitted),
        .cfg_set1_large  (cfg_set1_large),
        .in_range        (map_in),
        .set_sel         (map_set),
        .bank_sel        (map_bank),
        .row             (map_row)
    );

    ilv_secded_enc u_enc (
        .data (r_wdata),
        .ecc  (wr_ecc)
    );

    assign rd_word = bank_rdata[int'(r_bank)*CW +: CW];

    ilv_secded_dec u_dec (
        .word  (rd_word),
        .data  (dec_data),
        .fixed (dec_fixed),
        .fatal (dec_fatal)
    );

    assign sel_ready  = bank_ready[r_bank];
    assign sel_rvalid = bank_rvalid[r_bank];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = map_in ? ST_ISSUE : ST_RESP;
            ST_ISSUE:  if (sel_ready) state_nx = r_write ? ST_RESP : ST_WAITRD;
            ST_WAITRD: if (sel_rvalid) state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr    <= '0;
            r_write   <= 1'b0;
            r_wdata   <= '0;
            r_set     <= 1'b0;
            r_bank    <= 1'b0;
            r_row     <= '0;
            r_code    <= RSP_OK;
            r_rdata   <= '0;
            r_ue_addr <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                r_addr  <= req_addr;
                r_write <= req_write;
                r_wdata <= req_wdata;
                r_set   <= map_set;
                r_bank  <= map_bank;
                r_row   <= map_row;
                r_code  <= map_in ? RSP_OK : RSP_RANGE;
                r_rdata <= '0;
            end
            if (state == ST_WAITRD && sel_rvalid) begin
                r_rdata <= dec_data;
                if (dec_fatal) begin
                    r_code    <= RSP_FATAL;
                    r_ue_addr <= r_addr;
                end else if (dec_fixed) begin
                    r_code <= RSP_FIXED;
                end else begin
                    r_code <= RSP_OK;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        rsp_valid  = (state == ST_RESP);
        rsp_code   = r_code;
        rsp_rdata  = r_rdata;
        ce_pulse   = (state == ST_RESP) && (r_code == RSP_FIXED);
        ue_addr    = r_ue_addr;
        bank_we    = r_write;
        bank_addr  = {r_set, r_row};
        bank_wdata = {wr_ecc, r_wdata};
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign bank_req[g] = (state == ST_ISSUE) && (r_bank == 1'(g));
    end

    AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_req)); // R1
    AST_BANK_BY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_req) |-> bank_req[r_addr[3]]); // R1
    AST_RANGE_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_RANGE) |-> !$past(|bank_req)); // R6
    AST_UE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_FATAL) |-> (ue_addr == r_addr)); // R4
    AST_CE_ONLY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |-> (rsp_valid && rsp_code == RSP_FIXED)); // R3
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_req) |-> !req_ready); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bank_req) && !sel_ready) |=> ((|bank_req) && $stable(bank_addr))); // R7

endmodule

// File: tb/ilv_ecc_mapper_tb.sv
`timescale 1ns/1ps
module ilv_ecc_mapper_tb_top;

    localparam int ADDR_W = 27;
    localparam int VW     = 55;
    localparam int NV     = 16;

    // {cfg{set1_large,set1_fitted,set0_large}, addr, in, set, bank, row}
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'b000, 27'h0000008, 1'b1, 1'b0, 1'b1, 22'h000000},
        {3'b000, 27'h0FFFFF0, 1'b1, 1'b0, 1'b0, 22'h0FFFFF},
        {3'b000, 27'h1000000, 1'b0, 1'b0, 1'b0, 22'h000000},
        {3'b010, 27'h1000010, 1'b1, 1'b1, 1'b0, 22'h000001},
        {3'b010, 27'h1FFFFF8, 1'b1, 1'b1, 1'b1, 22'h0FFFFF},
        {3'b010, 27'h2000000, 1'b0, 1'b0, 1'b0, 22'h000000},
        {3'b001, 27'h3FFFFF8, 1'b1, 1'b0, 1'b1, 22'h3FFFFF},
        {3'b001, 27'h4000000, 1'b0, 1'b0, 1'b0, 22'h000000},
        {3'b110, 27'h0000000, 1'b1, 1'b1, 1'b0, 22'h000000},
        {3'b110, 27'h3FFFFF0, 1'b1, 1'b1, 1'b0, 22'h3FFFFF},
        {3'b110, 27'h4000008, 1'b1, 1'b0, 1'b1, 22'h000000},
        {3'b110, 27'h4FFFFF0, 1'b1, 1'b0, 1'b0, 22'h0FFFFF},
        {3'b110, 27'h5000000, 1'b0, 1'b0, 1'b0, 22'h000000},
        {3'b011, 27'h4000000, 1'b1, 1'b1, 1'b0, 22'h000000},
        {3'b111, 27'h7FFFFF8, 1'b1, 1'b1, 1'b1, 22'h3FFFFF},
        {3'b111, 27'h4000018, 1'b1, 1'b1, 1'b1, 22'h000001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_set0_large = 1'b0, cfg_set1_fitted = 1'b0, cfg_set1_large = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic req_ready, rsp_valid, ce_pulse, bank_we;
    logic [1:0] rsp_code, bank_req, bank_ready, bank_rvalid;
    logic [63:0] rsp_rdata;
    logic [ADDR_W-1:0] ue_addr;
    logic [22:0] bank_addr;
    logic [71:0] bank_wdata;
    logic [143:0] bank_rdata;

    always #4 clk = ~clk;

    ilv_ecc_mapper dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_set0_large(cfg_set0_large), .cfg_set1_fitted(cfg_set1_fitted),
        .cfg_set1_large(cfg_set1_large),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .ce_pulse(ce_pulse), .ue_addr(ue_addr),
        .bank_req(bank_req), .bank_we(bank_we), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_ready(bank_ready),
        .bank_rvalid(bank_rvalid), .bank_rdata(bank_rdata)
    );

    // Bank model
    logic [71:0] bmem [0:1][0:127];
    logic [71:0] rd [0:1];
    logic [7:0]  scnt [0:1];
    logic [71:0] flip_mask = '0;
    int          stall = 0;
    int          hs_count = 0;
    logic        last_bank, last_set, last_we;
    logic [21:0] last_row;
    logic [71:0] last_wdata;

    assign bank_rdata = {rd[1], rd[0]};
    always_comb begin
        for (int b = 0; b < 2; b++) bank_ready[b] = (int'(scnt[b]) >= stall);
    end

    always @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (!rst_n) begin
                scnt[b]        <= '0;
                bank_rvalid[b] <= 1'b0;
                rd[b]          <= '0;
            end else if (bank_req[b] && bank_ready[b]) begin
                scnt[b]    <= '0;
                hs_count   <= hs_count + 1;
                last_bank  <= 1'(b);
                last_set   <= bank_addr[22];
                last_row   <= bank_addr[21:0];
                last_we    <= bank_we;
                last_wdata <= bank_wdata;
                if (bank_we) bmem[b][{bank_addr[22], bank_addr[5:0]}] <= bank_wdata;
                else rd[b] <= bmem[b][{bank_addr[22], bank_addr[5:0]}] ^ flip_mask;
                bank_rvalid[b] <= !bank_we;
            end else begin
                bank_rvalid[b] <= 1'b0;
                if (bank_req[b]) scnt[b] <= scnt[b] + 8'd1;
            end
        end
    end

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog R7 actual=%0d expected=<50000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    logic [1:0]  g_code;
    logic [63:0] g_data;
    logic        g_ce, g_busy;
    int          g_lat;

    task automatic do_req(input logic we, input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        g_busy = req_ready;
        g_lat = 1;
        while (!rsp_valid && g_lat < 200) begin
            @(negedge clk);
            g_lat++;
        end
        g_code = rsp_code;
        g_data = rsp_rdata;
        g_ce   = ce_pulse;
        @(negedge clk);
        chk("R7 rsp_valid single cycle", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        logic [VW-1:0] v;
        logic [ADDR_W-1:0] a;
        logic [63:0] d;
        int hs0, lat0;

        repeat (4) @(negedge clk);
        chk("R7 reset req_ready", 64'(req_ready), 64'd1);
        chk("R7 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 reset bank_req", 64'(bank_req), 64'd0);
        chk("R4 reset ue_addr", 64'(ue_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: decode, banking, round trip, range
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            {cfg_set1_large, cfg_set1_fitted, cfg_set0_large} = v[54:52];
            a = v[51:25];
            d = {32'hC0DE0000 | 32'(i), 5'b0, a};
            hs0 = hs_count;
            do_req(1'b1, a, d);
            if (v[24]) begin
                chk("R2 write code", 64'(g_code), 64'd0);
                chk("R1 one bank access", 64'(hs_count - hs0), 64'd1);
                chk("R1 bank select", 64'(last_bank), 64'(v[22]));
                chk("R5 set index", 64'(last_set), 64'(v[23]));
                chk("R5 row", 64'(last_row), 64'(v[21:0]));
                chk("R2 data field", last_wdata[63:0], d);
                do_req(1'b0, a, '0);
                chk("R2 read code", 64'(g_code), 64'd0);
                chk("R2 read data", g_data, d);
                chk("R3 no ce on clean", 64'(g_ce), 64'd0);
            end else begin
                chk("R6 write range code", 64'(g_code), 64'd3);
                do_req(1'b0, a, '0);
                chk("R6 read range code", 64'(g_code), 64'd3);
                chk("R6 no bank access", 64'(hs_count - hs0), 64'd0);
            end
        end

        // Error injection on a 128MB map
        {cfg_set1_large, cfg_set1_fitted, cfg_set0_large} = 3'b111;
        a = 27'h0000100;
        d = 64'h0123_4567_89AB_CDEF;
        do_req(1'b1, a, d);
        for (int k = 0; k < 4; k++) begin
            int bitpos;
            bitpos = (k == 0) ? 5 : (k == 1) ? 66 : (k == 2) ? 71 : 63;
            flip_mask = 72'(1) << bitpos;
            do_req(1'b0, a, '0);
            chk("R3 single flip code", 64'(g_code), 64'd1);
            chk("R3 single flip data", g_data, d);
            chk("R3 ce_pulse", 64'(g_ce), 64'd1);
        end
        flip_mask = (72'(1) << 0) | (72'(1) << 40);
        do_req(1'b0, a, '0);
        chk("R4 double flip code", 64'(g_code), 64'd2);
        chk("R4 ue_addr", 64'(ue_addr), 64'(a));
        chk("R4 no ce on double", 64'(g_ce), 64'd0);

        a = 27'h2000048;
        do_req(1'b1, a, ~d);
        flip_mask = (72'(1) << 64) | (72'(1) << 70);
        do_req(1'b0, a, '0);
        chk("R4 double check-byte code", 64'(g_code), 64'd2);
        chk("R4 ue_addr second", 64'(ue_addr), 64'(a));
        flip_mask = '0;
        do_req(1'b0, 27'h0000100, '0);
        chk("R4 ue_addr held", 64'(ue_addr), 64'(a));
        chk("R2 clean after errors", g_data, d);

        // Stall behaviour
        stall = 0;
        do_req(1'b1, 27'h0000208, d);
        lat0 = g_lat;
        stall = 4;
        do_req(1'b1, 27'h0000208, ~d);
        chk("R7 stall latency", 64'(g_lat - lat0), 64'd4);
        chk("R7 busy req_ready", 64'(g_busy), 64'd0);
        do_req(1'b0, 27'h0000208, '0);
        chk("R7 stalled read data", g_data, ~d);
        stall = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule